// File: doc/BRIEF.md
# Limited-Pointer Sharing Directory

This block keeps the sharing state for a small set of memory blocks in a multiprocessor with `P` caches. Each block records up to `K` sharers as cache pointers, each `log2(P)` bits wide, and an exclusive-owner flag. Caches send read-share, write-exclusive and evict requests. For each request the directory works out which caches must give up their copy. It issues those invalidations one at a time on a stream port, or as a single broadcast. It counts the acknowledgements, and then returns a one-cycle grant to the requester.

If a new reader arrives when all `K` pointers of a block are in use, the overflow policy chosen on `ovf_mode` decides what happens. In broadcast mode the block is marked so that its next write invalidates every cache. In victim mode one existing sharer, picked by a free-running LFSR, is invalidated and its slot goes to the newcomer. In region mode the block switches to a coarse vector in which each bit covers `R` consecutive caches.

Requests use a valid/ready handshake. `req_ready` is high only while the directory is idle, so each accepted request holds off every later request until its grant cycle has passed. Invalidations use valid/ready as well. While `inv_ready` is low, `inv_valid` and its payload stay unchanged. Acknowledgements and the grant are single-cycle pulses with no back-pressure.

Top module: `dir_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `inv_valid` and `gnt_valid` are 0. Every block starts uncached.
- R2: A request that needs no invalidation is granted in the cycle right after it is accepted. Read (`req_op`=0) by a new cache of a non-exclusive block with a free pointer is such a request.
- R3: A write (`req_op`=1) sends one point-to-point invalidation to each cache held in the block's pointers, except the requester, in ascending cache number. The grant comes only after every acknowledgement. Afterwards the requester is the sole, exclusive holder.
- R4: A read of an exclusively held block by another cache invalidates the owner before the grant. Afterwards the reader is the only sharer.
- R5: Overflow mode 0 (broadcast): a reader beyond `K` is granted with no invalidation. The next write issues exactly one invalidation with `inv_bcast`=1 and `inv_cache` equal to the requester, and waits for `P`-1 acknowledgements.
- R6: Overflow mode 1 (victim): a reader beyond `K` causes exactly one invalidation to one of the current sharers and takes its slot. A later write invalidates the remaining `K`-1 old sharers and the newcomer.
- R7: Overflow mode 2 (region): a reader beyond `K` is granted with no invalidation and the block switches to region bits, where cache c lies in region c/`R`. A later write invalidates every cache of every marked region except the requester.
- R8: Evict (`req_op`=2) by a sharer frees its pointer for a later reader. Evict by the exclusive owner, or by the last sharer, leaves the block uncached, so a following write sends no invalidation.
- R9: While `inv_ready` is low, `inv_valid` stays high with unchanged `inv_cache` and `inv_bcast`. `req_ready` is low from acceptance until the grant cycle has ended.
- R10: `gnt_valid` is a one-cycle pulse carrying the requester in `gnt_cache` and the block index in `gnt_blk`.
- R11: `req_op`=3 is granted without invalidation and leaves the block's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_mode | input | 2 | Overflow policy: 0 broadcast, 1 victim, 2 region, 3 as 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle, request taken this cycle |
| req_op | input | 2 | 0 read-share, 1 write-exclusive, 2 evict, 3 no-op |
| req_cache | input | log2(P) | Requesting cache |
| req_blk | input | log2(NBLK) | Tracked block index |
| inv_valid | output | 1 | Invalidation offered |
| inv_ready | input | 1 | Network takes the invalidation |
| inv_cache | output | log2(P) | Target cache, or the excluded requester when broadcasting |
| inv_bcast | output | 1 | Invalidation goes to every cache except `inv_cache` |
| ack_valid | input | 1 | One invalidation acknowledgement |
| gnt_valid | output | 1 | Grant pulse |
| gnt_cache | output | log2(P) | Granted cache |
| gnt_blk | output | log2(NBLK) | Granted block |

## Verification
A request accepted at one rising edge either shows `gnt_valid` in the very next cycle, when no invalidation is due, or shows its first `inv_valid` in that cycle. The grant then follows one cycle after the edge at which the last acknowledgement is counted and nothing remains to send. The bench drives every input on the falling edge and samples on the falling edge. It acknowledges each invalidation on the falling edge at which it sees it taken, so the number of acknowledgements still owed at the grant must be zero. For requests with nothing to invalidate, the bench checks that the grant arrives exactly one cycle after acceptance. The victim picked in victim mode is read from the port and not predicted.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    DOP_READ  = 2'd0,
    DOP_WRITE = 2'd1,
    DOP_EVICT = 2'd2,
    DOP_NONE  = 2'd3
  } dop_e;

  typedef enum logic [1:0] {
    OVF_BCAST  = 2'd0,
    OVF_VICTIM = 2'd1,
    OVF_REGION = 2'd2,
    OVF_RSVD   = 2'd3
  } ovf_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GNT  = 2'd2
  } dst_e;
endpackage

// File: rtl/dir_lfsr.sv
module dir_lfsr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = q[W-1] ^ q[W-3] ^ q[W-4] ^ q[W-5];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= {{(W-1){1'b0}}, 1'b1};
    else        q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/dir_plan.sv
module dir_plan
  import dir_pkg::*;
#(
  parameter int P = 16,
  parameter int K = 4,
  parameter int R = 4,
  localparam int IDW = $clog2(P),
  localparam int NR  = P / R,
  localparam int RW  = $clog2(R),
  localparam int IW  = (NR > 1) ? $clog2(NR) : 1,
  localparam int KW  = (K > 1) ? $clog2(K) : 1
) (
  input  logic [1:0]              op,
  input  logic [1:0]              mode,
  input  logic [IDW-1:0]          cache,
  input  logic [KW-1:0]           vic,
  input  logic [K-1:0]            pv,
  input  logic [K-1:0][IDW-1:0]   pid,
  input  logic                    excl,
  input  logic                    bc,
  input  logic                    cvon,
  input  logic [NR-1:0]           cv,
  output logic [K-1:0]            n_pv,
  output logic [K-1:0][IDW-1:0]   n_pid,
  output logic                    n_excl,
  output logic                    n_bc,
  output logic                    n_cvon,
  output logic [NR-1:0]           n_cv,
  output logic [P-1:0]            tgt,
  output logic                    tbc
);
  logic [K-1:0]  hit;
  logic [P-1:0]  ptr_mask, reg_mask, req_oh;
  logic [NR-1:0] ptr_reg;
  logic [KW-1:0] free_idx;
  logic          full;
  logic [IW-1:0] req_reg;

  for (genvar gi = 0; gi < K; gi++) begin : g_hit
    assign hit[gi] = pv[gi] && (pid[gi] == cache);
  end

  for (genvar gj = 0; gj < P; gj++) begin : g_reg
    assign reg_mask[gj] = cv[gj / R];
  end

  assign full    = &pv;
  assign req_oh  = {{(P-1){1'b0}}, 1'b1} << cache;
  assign req_reg = IW'(cache >> RW);

  always_comb begin
    ptr_mask = '0;
    ptr_reg  = '0;
    free_idx = '0;
    for (int i = K - 1; i >= 0; i--) begin
      if (pv[i]) begin
        ptr_mask[pid[i]] = 1'b1;
        ptr_reg[IW'(pid[i] >> RW)] = 1'b1;
      end else begin
        free_idx = KW'(i);
      end
    end
  end

  always_comb begin
    n_pv   = pv;
    n_pid  = pid;
    n_excl = excl;
    n_bc   = bc;
    n_cvon = cvon;
    n_cv   = cv;
    tgt    = '0;
    tbc    = 1'b0;
    case (dop_e'(op))
      DOP_READ: begin
        if (excl) begin
          if (pid[0] != cache) begin
            tgt       = ptr_mask & ~req_oh;
            n_pv      = '0;
            n_pv[0]   = 1'b1;
            n_pid[0]  = cache;
            n_excl    = 1'b0;
          end
        end else if (cvon) begin
          n_cv[req_reg] = 1'b1;
        end else if (|hit) begin
          n_pv = pv;
        end else if (!full) begin
          n_pv[free_idx]  = 1'b1;
          n_pid[free_idx] = cache;
        end else begin
          case (ovf_e'(mode))
            OVF_VICTIM: begin
              tgt[pid[vic]] = 1'b1;
              n_pid[vic]    = cache;
            end
            OVF_REGION: begin
              n_cvon = 1'b1;
              n_cv   = cv | ptr_reg;
              n_cv[req_reg] = 1'b1;
              n_pv   = '0;
            end
            default: n_bc = 1'b1;
          endcase
        end
      end
      DOP_WRITE: begin
        if (bc)        tbc = 1'b1;
        else if (cvon) tgt = reg_mask & ~req_oh;
        else           tgt = ptr_mask & ~req_oh;
        n_pv     = '0;
        n_pv[0]  = 1'b1;
        n_pid[0] = cache;
        n_excl   = 1'b1;
        n_bc     = 1'b0;
        n_cvon   = 1'b0;
        n_cv     = '0;
      end
      DOP_EVICT: begin
        if (excl) begin
          if (pid[0] == cache) begin
            n_pv   = '0;
            n_excl = 1'b0;
          end
        end else if (!cvon) begin
          n_pv = pv & ~hit;
        end
      end
      default: n_pv = pv;
    endcase
  end
endmodule

// File: rtl/dir_invseq.sv
module dir_invseq #(
  parameter int P = 16,
  localparam int IDW = $clog2(P),
  localparam int CW  = $clog2(P + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [P-1:0]   load_mask,
  input  logic           load_bc,
  input  logic [IDW-1:0] load_req,
  input  logic           inv_ready,
  input  logic           ack_valid,
  output logic           inv_valid,
  output logic [IDW-1:0] inv_cache,
  output logic           inv_bcast,
  output logic           drained
);
  logic [P-1:0]   mask_q;
  logic           bc_q;
  logic [IDW-1:0] req_q, low;
  logic [CW-1:0]  out_q, add, sub;
  logic           fire;

  always_comb begin
    low = '0;
    for (int i = P - 1; i >= 0; i--) begin
      if (mask_q[i]) low = IDW'(i);
    end
  end

  assign inv_valid = (|mask_q) | bc_q;
  assign inv_bcast = bc_q;
  assign inv_cache = bc_q ? req_q : low;
  assign drained   = (out_q == '0);
  assign fire      = inv_valid & inv_ready;
  assign add       = !fire ? '0 : (bc_q ? CW'(P - 1) : CW'(1));
  assign sub       = (ack_valid && (out_q != '0 || fire)) ? CW'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      bc_q   <= 1'b0;
      req_q  <= '0;
      out_q  <= '0;
    end else begin
      out_q <= out_q + add - sub;
      if (load) begin
        mask_q <= load_mask;
        bc_q   <= load_bc;
        req_q  <= load_req;
      end else if (fire) begin
        if (bc_q) bc_q <= 1'b0;
        else      mask_q[low] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int P    = 16,
  parameter int K    = 4,
  parameter int R    = 4,
  parameter int NBLK = 8,
  localparam int IDW = $clog2(P),
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int NR  = P / R,
  localparam int KW  = (K > 1) ? $clog2(K) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     ovf_mode,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [IDW-1:0] req_cache,
  input  logic [BW-1:0]  req_blk,
  output logic           inv_valid,
  input  logic           inv_ready,
  output logic [IDW-1:0] inv_cache,
  output logic           inv_bcast,
  input  logic           ack_valid,
  output logic           gnt_valid,
  output logic [IDW-1:0] gnt_cache,
  output logic [BW-1:0]  gnt_blk
);
  logic [K-1:0]            pv_q   [NBLK];
  logic [K-1:0][IDW-1:0]   pid_q  [NBLK];
  logic [NR-1:0]           cv_q   [NBLK];
  logic [NBLK-1:0]         excl_q, bc_q, cvon_q;

  logic [K-1:0]            c_pv,  p_pv;
  logic [K-1:0][IDW-1:0]   c_pid, p_pid;
  logic                    c_excl, c_bc, c_cvon, p_excl, p_bc, p_cvon;
  logic [NR-1:0]           c_cv,  p_cv;
  logic [P-1:0]            tgt;
  logic                    tbc, accept, drained;
  logic [7:0]              lfsr_q;
  logic [KW-1:0]           vic;
  logic [IDW-1:0]          pc_q;
  logic [BW-1:0]           pb_q;
  dst_e                    st_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign gnt_valid = (st_q == ST_GNT);
  assign gnt_cache = pc_q;
  assign gnt_blk   = pb_q;
  assign vic       = KW'(lfsr_q % 8'(K));

  dir_lfsr #(.W(8)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(lfsr_q));

  dir_plan #(.P(P), .K(K), .R(R)) u_plan (
    .op(req_op), .mode(ovf_mode), .cache(req_cache), .vic(vic),
    .pv(pv_q[req_blk]), .pid(pid_q[req_blk]), .excl(excl_q[req_blk]),
    .bc(bc_q[req_blk]), .cvon(cvon_q[req_blk]), .cv(cv_q[req_blk]),
    .n_pv(c_pv), .n_pid(c_pid), .n_excl(c_excl), .n_bc(c_bc),
    .n_cvon(c_cvon), .n_cv(c_cv), .tgt(tgt), .tbc(tbc)
  );

  dir_invseq #(.P(P)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_mask(tgt),
    .load_bc(tbc), .load_req(req_cache), .inv_ready(inv_ready),
    .ack_valid(ack_valid), .inv_valid(inv_valid), .inv_cache(inv_cache),
    .inv_bcast(inv_bcast), .drained(drained)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      pb_q   <= '0;
      p_pv   <= '0;
      p_pid  <= '0;
      p_excl <= 1'b0;
      p_bc   <= 1'b0;
      p_cvon <= 1'b0;
      p_cv   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          pc_q   <= req_cache;
          pb_q   <= req_blk;
          p_pv   <= c_pv;
          p_pid  <= c_pid;
          p_excl <= c_excl;
          p_bc   <= c_bc;
          p_cvon <= c_cvon;
          p_cv   <= c_cv;
          st_q   <= ((|tgt) || tbc) ? ST_WAIT : ST_GNT;
        end
        ST_WAIT: if (!inv_valid && drained) st_q <= ST_GNT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q <= '0;
      bc_q   <= '0;
      cvon_q <= '0;
      for (int b = 0; b < NBLK; b++) begin
        pv_q[b]  <= '0;
        pid_q[b] <= '0;
        cv_q[b]  <= '0;
      end
    end else if (st_q == ST_GNT) begin
      pv_q[pb_q]   <= p_pv;
      pid_q[pb_q]  <= p_pid;
      cv_q[pb_q]   <= p_cv;
      excl_q[pb_q] <= p_excl;
      bc_q[pb_q]   <= p_bc;
      cvon_q[pb_q] <= p_cvon;
    end
  end
endmodule

// File: rtl/dir_chk.sv
module dir_chk #(
  parameter int P = 16,
  localparam int IDW = $clog2(P)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           inv_valid,
  input logic           inv_ready,
  input logic [IDW-1:0] inv_cache,
  input logic           inv_bcast,
  input logic           gnt_valid
);
  p_inv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_cache) && $stable(inv_bcast));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_gnt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid);

  p_no_gnt_in_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !gnt_valid && !req_ready);
endmodule

bind dir_ctrl dir_chk #(.P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_cache(inv_cache),
  .inv_bcast(inv_bcast), .gnt_valid(gnt_valid)
);

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  localparam int PER = 10;
  localparam int P = 16;

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  blk;
    logic [1:0]  mode;
    logic [1:0]  op;
    logic [3:0]  c;
    logic [4:0]  n;
    logic        bc;
    logic [15:0] mask;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    // block 0, broadcast overflow
    '{4'd2, 3'd0, 2'd0, 2'd0, 4'd1, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd0, 2'd0, 2'd0, 4'd2, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd0, 2'd0, 2'd0, 4'd3, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd0, 2'd0, 2'd0, 4'd4, 5'd0, 1'b0, 16'h0000},
    '{4'd5, 3'd0, 2'd0, 2'd0, 4'd5, 5'd0, 1'b0, 16'h0000}, // R5 overflow
    '{4'd5, 3'd0, 2'd0, 2'd1, 4'd2, 5'd1, 1'b1, 16'h0000}, // R5 broadcast
    '{4'd4, 3'd0, 2'd0, 2'd0, 4'd7, 5'd1, 1'b0, 16'h0004}, // R4 owner 2
    '{4'd3, 3'd0, 2'd0, 2'd1, 4'd7, 5'd0, 1'b0, 16'h0000}, // R3 self only
    // block 1, region overflow
    '{4'd2, 3'd1, 2'd2, 2'd0, 4'd0, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd1, 2'd2, 2'd0, 4'd1, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd1, 2'd2, 2'd0, 4'd5, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd1, 2'd2, 2'd0, 4'd6, 5'd0, 1'b0, 16'h0000},
    '{4'd7, 3'd1, 2'd2, 2'd0, 4'd2, 5'd0, 1'b0, 16'h0000}, // R7 switch
    '{4'd7, 3'd1, 2'd2, 2'd1, 4'd1, 5'd7, 1'b0, 16'h00FD}, // R7 regions 0,1
    // block 2, plain write, owner evict
    '{4'd2, 3'd2, 2'd0, 2'd0, 4'd3,  5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd2, 2'd0, 2'd0, 4'd8,  5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd2, 2'd0, 2'd0, 4'd12, 5'd0, 1'b0, 16'h0000},
    '{4'd3, 3'd2, 2'd0, 2'd1, 4'd8,  5'd2, 1'b0, 16'h1008}, // R3
    '{4'd8, 3'd2, 2'd0, 2'd2, 4'd8,  5'd0, 1'b0, 16'h0000}, // R8 owner leaves
    '{4'd8, 3'd2, 2'd0, 2'd1, 4'd5,  5'd0, 1'b0, 16'h0000}, // R8 uncached
    // block 3, sharer evicts and no-op
    '{4'd2, 3'd3, 2'd0, 2'd0, 4'd1, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd3, 2'd0, 2'd0, 4'd2, 5'd0, 1'b0, 16'h0000},
    '{4'd8, 3'd3, 2'd0, 2'd2, 4'd1, 5'd0, 1'b0, 16'h0000},
    '{4'd8, 3'd3, 2'd0, 2'd2, 4'd2, 5'd0, 1'b0, 16'h0000},
    '{4'd8, 3'd3, 2'd0, 2'd1, 4'd9, 5'd0, 1'b0, 16'h0000}, // R8 last left
    '{4'd4, 3'd3, 2'd0, 2'd0, 4'd4, 5'd1, 1'b0, 16'h0200}, // R4 owner 9
    '{4'd11,3'd3, 2'd0, 2'd3, 4'd6, 5'd0, 1'b0, 16'h0000}, // R11
    '{4'd11,3'd3, 2'd0, 2'd1, 4'd6, 5'd1, 1'b0, 16'h0010}, // R11 state kept
    // block 4, freed slot reused
    '{4'd2, 3'd4, 2'd0, 2'd0, 4'd1, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd4, 2'd0, 2'd0, 4'd2, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd4, 2'd0, 2'd0, 4'd3, 5'd0, 1'b0, 16'h0000},
    '{4'd2, 3'd4, 2'd0, 2'd0, 4'd4, 5'd0, 1'b0, 16'h0000},
    '{4'd8, 3'd4, 2'd0, 2'd2, 4'd3, 5'd0, 1'b0, 16'h0000},
    '{4'd8, 3'd4, 2'd0, 2'd0, 4'd5, 5'd0, 1'b0, 16'h0000}, // R8 slot reused
    '{4'd8, 3'd4, 2'd0, 2'd1, 4'd6, 5'd4, 1'b0, 16'h0036}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ovf_mode = '0, req_op = '0;
  logic       req_valid = 1'b0, inv_ready = 1'b1, ack_valid = 1'b0;
  logic [3:0] req_cache = '0, inv_cache, gnt_cache;
  logic [2:0] req_blk = '0, gnt_blk;
  logic       req_ready, inv_valid, inv_bcast, gnt_valid;

  int total = 0, bad = 0;
  int r_n, r_lat, r_owed, r_x;
  logic r_bc, r_ord;
  logic [15:0] r_mask;
  logic [3:0]  r_gc;
  logic [2:0]  r_gb;

  always #(PER/2) clk = ~clk;

  dir_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ovf_mode(ovf_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_cache(req_cache),
    .req_blk(req_blk), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_cache(inv_cache), .inv_bcast(inv_bcast), .ack_valid(ack_valid),
    .gnt_valid(gnt_valid), .gnt_cache(gnt_cache), .gnt_blk(gnt_blk)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] b, input logic [1:0] m, input logic [1:0] op,
                     input logic [3:0] c, input int hold_in);
    int owed, last, cyc, hold;
    logic done;
    logic [3:0] hc;
    hold = hold_in;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ovf_mode = m; req_op = op; req_cache = c; req_blk = b; req_valid = 1'b1;
    inv_ready = (hold == 0);
    @(posedge clk);
    r_n = 0; r_bc = 1'b0; r_mask = '0; r_ord = 1'b1; r_x = -1;
    owed = 0; last = -1; cyc = 0; done = 1'b0; hc = '0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      req_valid = 1'b0;
      if (gnt_valid) begin
        done = 1'b1; r_lat = cyc; r_gc = gnt_cache; r_gb = gnt_blk; r_owed = owed;
        ack_valid = 1'b0; inv_ready = 1'b1;
      end else begin
        if (hold > 0) begin
          inv_ready = 1'b0;
          if (cyc == 1) hc = inv_cache;
          chk(inv_valid && inv_cache == hc && !req_ready, "R9 held invalidation",
              int'(inv_cache), int'(hc));
          hold--;
        end else inv_ready = 1'b1;
        if (inv_valid && inv_ready) begin
          r_n++;
          if (inv_bcast) begin
            r_bc = 1'b1; owed += P - 1;
            chk(inv_cache == c, "R5 broadcast excluded cache", int'(inv_cache), int'(c));
          end else begin
            r_mask[inv_cache] = 1'b1; r_x = int'(inv_cache);
            if (int'(inv_cache) <= last) r_ord = 1'b0;
            last = int'(inv_cache); owed++;
          end
        end
        if (owed > 0) begin ack_valid = 1'b1; owed--; end
        else ack_valid = 1'b0;
        if (cyc > 400) begin
          chk(1'b0, "watchdog in request", cyc, 400);
          done = 1'b1; r_lat = cyc; r_owed = 0; r_gc = c; r_gb = b;
        end
      end
    end
  endtask

  task automatic verify(input string rq, input logic [2:0] b, input logic [3:0] c,
                        input int n, input logic bc, input logic [15:0] mask);
    chk(r_n == n, rq, r_n, n);
    chk(r_bc == bc, rq, int'(r_bc), int'(bc));
    chk(r_mask == mask, rq, int'(r_mask), int'(mask));
    chk(r_ord, "R3 ascending order", int'(r_ord), 1);
    chk(r_owed == 0, "R3 grant after all acks", r_owed, 0);
    chk(r_gc == c, "R10 grant cache", int'(r_gc), int'(c));
    chk(r_gb == b, "R10 grant block", int'(r_gb), int'(b));
    if (n == 0) chk(r_lat == 1, "R2 grant latency", r_lat, 1);
  endtask

  initial begin
    #(PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x;
    logic [15:0] em;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && inv_valid == 1'b0 && gnt_valid == 1'b0, "R1 in reset",
        int'({req_ready, inv_valid, gnt_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(inv_valid == 1'b0 && gnt_valid == 1'b0, "R1 quiet after reset",
        int'({inv_valid, gnt_valid}), 0);

    for (int i = 0; i < NV; i++) begin
      run(TBL[i].blk, TBL[i].mode, TBL[i].op, TBL[i].c, 0);
      verify($sformatf("R%0d vector %0d", TBL[i].rq, i), TBL[i].blk, TBL[i].c,
             int'(TBL[i].n), TBL[i].bc, TBL[i].mask);
    end

    // R6 victim overflow on block 5
    for (int c = 1; c <= 4; c++) begin
      run(3'd5, 2'd1, 2'd0, 4'(c), 0);
      verify("R6 fill", 3'd5, 4'(c), 0, 1'b0, 16'h0000);
    end
    run(3'd5, 2'd1, 2'd0, 4'd5, 0);
    x = r_x;
    chk(r_n == 1 && !r_bc, "R6 one victim", r_n, 1);
    chk(x >= 1 && x <= 4, "R6 victim is a sharer", x, 1);
    em = 16'h003E;
    if (x >= 0 && x < 16) em[x] = 1'b0;
    run(3'd5, 2'd1, 2'd1, 4'd6, 0);
    verify("R6 write after victim", 3'd5, 4'd6, 4, 1'b0, em);

    // R9 back-pressure on block 6
    run(3'd6, 2'd0, 2'd0, 4'd1, 0);
    run(3'd6, 2'd0, 2'd0, 4'd2, 0);
    run(3'd6, 2'd0, 2'd1, 4'd3, 3);
    verify("R9 write under back-pressure", 3'd6, 4'd3, 2, 1'b0, 16'h0006);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule